// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This combinational block sits in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It produces the two operand values that the decode stage hands to the execute stage. Each operand either comes from the register-file read port or is bypassed from a younger result still travelling down the pipe. Those results are the ALU output being formed in execute this cycle, the ALU result and the load data held in the memory-stage register, and the ALU result and the load data held in the write-back register.

Where several stages write the same register, the youngest producer wins. For call and jump instructions, operand A carries the incremented program counter of the decode instruction in place of any register value. Operand B never has that case. A register ID equal to the all-ones code means "no register" and never causes a bypass. The pipeline registers, register file, ALU and stall logic live outside this block.

Top module: `fwd_operand_bypass`

## Requirements
- R1: When `dec_op` equals `CALL_OP` (default 4'h8) or `JUMP_OP` (default 4'h7), `opnd_a` equals `dec_next_pc`, whatever the source and destination IDs are.
- R2: Otherwise, an operand whose source ID equals `ex_alu_dst` takes `ex_alu_res`, the value the ALU produces in the same cycle, ahead of every other source.
- R3: Without an execute match, a source ID equal to `mem_load_dst` selects `mem_load_data` over the memory-stage ALU result and over both write-back values.
- R4: Without the two matches above, a source ID equal to `mem_alu_dst` selects `mem_alu_val` over both write-back values.
- R5: Without any memory or execute match, a source ID equal to `wb_load_dst` selects `wb_load_val` over `wb_alu_val`.
- R6: When the only match is `wb_alu_dst`, the operand is `wb_alu_val`.
- R7: When no destination matches, `opnd_a` is `rf_rd_a` and `opnd_b` is `rf_rd_b`.
- R8: A source ID of 4'hF never bypasses, even when a destination ID is also 4'hF. The operand is then the register-file value.
- R9: A destination ID of 4'hF matches no real source register.
- R10: `opnd_b` follows the bypass order for `dec_src_b` and is unaffected by `dec_op`, including call and jump codes.
- R11: The A and B operands are selected independently. One producer may feed both, and each may take a different producer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_op | input | OP_W (4) | Instruction code of the decode-stage instruction |
| dec_next_pc | input | DATA_W (32) | Incremented PC of the decode-stage instruction |
| dec_src_a | input | ID_W (4) | Source register ID for operand A (4'hF = none) |
| dec_src_b | input | ID_W (4) | Source register ID for operand B (4'hF = none) |
| rf_rd_a | input | DATA_W | Register-file read data for operand A |
| rf_rd_b | input | DATA_W | Register-file read data for operand B |
| ex_alu_dst | input | ID_W | ALU destination ID of the execute-stage instruction |
| ex_alu_res | input | DATA_W | ALU output computed in execute this cycle |
| mem_load_dst | input | ID_W | Load destination ID in the memory-stage register |
| mem_load_data | input | DATA_W | Data read from memory this cycle |
| mem_alu_dst | input | ID_W | ALU destination ID in the memory-stage register |
| mem_alu_val | input | DATA_W | ALU result held in the memory-stage register |
| wb_load_dst | input | ID_W | Load destination ID in the write-back register |
| wb_load_val | input | DATA_W | Load data held in the write-back register |
| wb_alu_dst | input | ID_W | ALU destination ID in the write-back register |
| wb_alu_val | input | DATA_W | ALU result held in the write-back register |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |

## Verification
The vectors aim at the same register being named by three, four or five stages at once. A priority chain in the wrong order would hand the execute stage a stale value from an older instruction. Other vectors pair the none code on both the source and a destination; an unguarded comparator would bypass garbage into an operand with no register. Call and jump codes are applied with a live execute match on both operands, which shows that the PC override reaches only A and does not leak into B. A directed step changes only the execute ALU value while the match holds, which catches a design that returns a registered or stale execute result.

// File: rtl/fwd_bypass_pkg.sv
`timescale 1ns/1ps
package fwd_bypass_pkg;

  // Number of bypass producers, ordered youngest first.
  localparam int unsigned N_PROD = 5;

  // Producer index, which is also the priority rank (0 = highest).
  typedef enum logic [2:0] {
    PROD_EX_ALU   = 3'd0,
    PROD_MEM_LOAD = 3'd1,
    PROD_MEM_ALU  = 3'd2,
    PROD_WB_LOAD  = 3'd3,
    PROD_WB_ALU   = 3'd4
  } prod_e;

endpackage

// File: rtl/fwd_id_match.sv
`timescale 1ns/1ps
// Compares one source register ID with one destination ID.
// The reserved none code never produces a hit from either side.
module fwd_id_match #(
  parameter int unsigned ID_W = 4,
  parameter logic [ID_W-1:0] NONE_ID = '1
) (
  input  logic [ID_W-1:0] src_id,
  input  logic [ID_W-1:0] dst_id,
  output logic            hit
);

  logic src_real;
  logic dst_real;
  logic same_id;

  always_comb begin
    src_real = (src_id != NONE_ID);
    dst_real = (dst_id != NONE_ID);
    same_id  = (src_id == dst_id);
    hit      = src_real && dst_real && same_id;
  end

endmodule

// File: rtl/fwd_prio_pick.sv
`timescale 1ns/1ps
// Fixed-priority one-hot grant: the lowest index that hits wins.
module fwd_prio_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] hit_vec,
  output logic [N-1:0] grant_oh,
  output logic         any_hit
);

  // blocked[i] is set when any index below i hits.
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_rank
    assign grant_oh[g]    = hit_vec[g] & ~blocked[g];
    assign blocked[g + 1] = blocked[g] | hit_vec[g];
  end

  assign any_hit = blocked[N];

endmodule

// File: rtl/fwd_operand_sel.sv
`timescale 1ns/1ps
// Selects one operand: optional PC override, then the bypass chain,
// then the register-file value.
module fwd_operand_sel #(
  parameter int unsigned     ID_W    = 4,
  parameter int unsigned     DATA_W  = 32,
  parameter int unsigned     N_PROD  = 5,
  parameter logic [ID_W-1:0] NONE_ID = '1,
  parameter bit              PC_CASE = 1'b0
) (
  input  logic [ID_W-1:0]               src_id,
  input  logic [N_PROD-1:0][ID_W-1:0]   prod_dst,
  input  logic [N_PROD-1:0][DATA_W-1:0] prod_val,
  input  logic [DATA_W-1:0]             rf_val,
  input  logic                          pc_take,
  input  logic [DATA_W-1:0]             pc_val,
  output logic [DATA_W-1:0]             operand
);

  logic [N_PROD-1:0] hit_vec;
  logic [N_PROD-1:0] grant_oh;
  logic              any_hit;
  logic [DATA_W-1:0] byp_val;
  logic [DATA_W-1:0] reg_path;

  for (genvar g = 0; g < N_PROD; g++) begin : g_cmp
    fwd_id_match #(
      .ID_W    (ID_W),
      .NONE_ID (NONE_ID)
    ) u_match (
      .src_id (src_id),
      .dst_id (prod_dst[g]),
      .hit    (hit_vec[g])
    );
  end

  fwd_prio_pick #(
    .N (N_PROD)
  ) u_pick (
    .hit_vec  (hit_vec),
    .grant_oh (grant_oh),
    .any_hit  (any_hit)
  );

  // AND-OR mux over the one-hot grant.
  always_comb begin
    byp_val = '0;
    for (int i = 0; i < N_PROD; i++) begin
      byp_val = byp_val | (prod_val[i] & {DATA_W{grant_oh[i]}});
    end
    reg_path = any_hit ? byp_val : rf_val;
  end

  if (PC_CASE) begin : g_pc
    assign operand = pc_take ? pc_val : reg_path;
  end else begin : g_no_pc
    logic unused_pc_inputs;
    assign unused_pc_inputs = ^{pc_take, pc_val};
    assign operand = reg_path;
  end

endmodule

// File: rtl/fwd_operand_bypass.sv
`timescale 1ns/1ps
// Decode-stage operand bypass selector (top).
module fwd_operand_bypass
  import fwd_bypass_pkg::*;
#(
  parameter int unsigned     ID_W    = 4,
  parameter int unsigned     DATA_W  = 32,
  parameter int unsigned     OP_W    = 4,
  parameter logic [OP_W-1:0] CALL_OP = 4'h8,
  parameter logic [OP_W-1:0] JUMP_OP = 4'h7,
  parameter logic [ID_W-1:0] NONE_ID = '1
) (
  input  logic [OP_W-1:0]   dec_op,
  input  logic [DATA_W-1:0] dec_next_pc,
  input  logic [ID_W-1:0]   dec_src_a,
  input  logic [ID_W-1:0]   dec_src_b,
  input  logic [DATA_W-1:0] rf_rd_a,
  input  logic [DATA_W-1:0] rf_rd_b,
  input  logic [ID_W-1:0]   ex_alu_dst,
  input  logic [DATA_W-1:0] ex_alu_res,
  input  logic [ID_W-1:0]   mem_load_dst,
  input  logic [DATA_W-1:0] mem_load_data,
  input  logic [ID_W-1:0]   mem_alu_dst,
  input  logic [DATA_W-1:0] mem_alu_val,
  input  logic [ID_W-1:0]   wb_load_dst,
  input  logic [DATA_W-1:0] wb_load_val,
  input  logic [ID_W-1:0]   wb_alu_dst,
  input  logic [DATA_W-1:0] wb_alu_val,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  logic [N_PROD-1:0][ID_W-1:0]   prod_dst;
  logic [N_PROD-1:0][DATA_W-1:0] prod_val;
  logic                          pc_take;

  // Pack producers in priority order, youngest first.
  always_comb begin
    prod_dst[PROD_EX_ALU]   = ex_alu_dst;
    prod_val[PROD_EX_ALU]   = ex_alu_res;
    prod_dst[PROD_MEM_LOAD] = mem_load_dst;
    prod_val[PROD_MEM_LOAD] = mem_load_data;
    prod_dst[PROD_MEM_ALU]  = mem_alu_dst;
    prod_val[PROD_MEM_ALU]  = mem_alu_val;
    prod_dst[PROD_WB_LOAD]  = wb_load_dst;
    prod_val[PROD_WB_LOAD]  = wb_load_val;
    prod_dst[PROD_WB_ALU]   = wb_alu_dst;
    prod_val[PROD_WB_ALU]   = wb_alu_val;
    pc_take = (dec_op == CALL_OP) || (dec_op == JUMP_OP);
  end

  fwd_operand_sel #(
    .ID_W    (ID_W),
    .DATA_W  (DATA_W),
    .N_PROD  (N_PROD),
    .NONE_ID (NONE_ID),
    .PC_CASE (1'b1)
  ) u_sel_a (
    .src_id   (dec_src_a),
    .prod_dst (prod_dst),
    .prod_val (prod_val),
    .rf_val   (rf_rd_a),
    .pc_take  (pc_take),
    .pc_val   (dec_next_pc),
    .operand  (opnd_a)
  );

  fwd_operand_sel #(
    .ID_W    (ID_W),
    .DATA_W  (DATA_W),
    .N_PROD  (N_PROD),
    .NONE_ID (NONE_ID),
    .PC_CASE (1'b0)
  ) u_sel_b (
    .src_id   (dec_src_b),
    .prod_dst (prod_dst),
    .prod_val (prod_val),
    .rf_val   (rf_rd_b),
    .pc_take  (1'b0),
    .pc_val   ({DATA_W{1'b0}}),
    .operand  (opnd_b)
  );

endmodule

// File: rtl/fwd_bypass_chk.sv
`timescale 1ns/1ps
// Port-level checker for the bypass selector.
module fwd_bypass_chk #(
  parameter int unsigned     ID_W    = 4,
  parameter int unsigned     DATA_W  = 32,
  parameter int unsigned     OP_W    = 4,
  parameter logic [OP_W-1:0] CALL_OP = 4'h8,
  parameter logic [OP_W-1:0] JUMP_OP = 4'h7,
  parameter logic [ID_W-1:0] NONE_ID = '1
) (
  input logic [OP_W-1:0]   dec_op,
  input logic [DATA_W-1:0] dec_next_pc,
  input logic [ID_W-1:0]   dec_src_a,
  input logic [ID_W-1:0]   dec_src_b,
  input logic [DATA_W-1:0] rf_rd_a,
  input logic [DATA_W-1:0] rf_rd_b,
  input logic [ID_W-1:0]   ex_alu_dst,
  input logic [DATA_W-1:0] ex_alu_res,
  input logic [ID_W-1:0]   mem_load_dst,
  input logic [ID_W-1:0]   mem_alu_dst,
  input logic [ID_W-1:0]   wb_load_dst,
  input logic [ID_W-1:0]   wb_alu_dst,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);

  logic is_pc_op;
  logic a_ex;
  logic b_ex;
  logic a_any;

  always_comb begin
    is_pc_op = (dec_op == CALL_OP) || (dec_op == JUMP_OP);
    a_ex  = (dec_src_a != NONE_ID) && (dec_src_a == ex_alu_dst);
    b_ex  = (dec_src_b != NONE_ID) && (dec_src_b == ex_alu_dst);
    a_any = (dec_src_a != NONE_ID) &&
            ((dec_src_a == ex_alu_dst) || (dec_src_a == mem_load_dst) ||
             (dec_src_a == mem_alu_dst) || (dec_src_a == wb_load_dst) ||
             (dec_src_a == wb_alu_dst));

    if (is_pc_op) begin
      // R1
      pc_pass_chk: assert (opnd_a == dec_next_pc)
        else $error("R1 opnd_a %h != next pc %h", opnd_a, dec_next_pc);
    end
    if (!is_pc_op && a_ex) begin
      // R2
      ex_first_a_chk: assert (opnd_a == ex_alu_res)
        else $error("R2 opnd_a %h != ex %h", opnd_a, ex_alu_res);
    end
    if (b_ex) begin
      // R10
      ex_first_b_chk: assert (opnd_b == ex_alu_res)
        else $error("R10 opnd_b %h != ex %h", opnd_b, ex_alu_res);
    end
    if (!is_pc_op && !a_any) begin
      // R7
      rf_default_a_chk: assert (opnd_a == rf_rd_a)
        else $error("R7 opnd_a %h != rf %h", opnd_a, rf_rd_a);
    end
    if (dec_src_b == NONE_ID) begin
      // R8
      none_src_b_chk: assert (opnd_b == rf_rd_b)
        else $error("R8 opnd_b %h != rf %h", opnd_b, rf_rd_b);
    end
  end

endmodule

bind fwd_operand_bypass fwd_bypass_chk #(
  .ID_W    (ID_W),
  .DATA_W  (DATA_W),
  .OP_W    (OP_W),
  .CALL_OP (CALL_OP),
  .JUMP_OP (JUMP_OP),
  .NONE_ID (NONE_ID)
) u_fwd_bypass_chk (
  .dec_op       (dec_op),
  .dec_next_pc  (dec_next_pc),
  .dec_src_a    (dec_src_a),
  .dec_src_b    (dec_src_b),
  .rf_rd_a      (rf_rd_a),
  .rf_rd_b      (rf_rd_b),
  .ex_alu_dst   (ex_alu_dst),
  .ex_alu_res   (ex_alu_res),
  .mem_load_dst (mem_load_dst),
  .mem_alu_dst  (mem_alu_dst),
  .wb_load_dst  (wb_load_dst),
  .wb_alu_dst   (wb_alu_dst),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b)
);

// File: tb/test_fwd_operand_bypass.sv
`timescale 1ns/1ps
module test_fwd_operand_bypass;

  localparam int unsigned ID_W   = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 4;

  // Fixed data pattern per producer
  localparam logic [31:0] V_EX  = 32'hE0E0_0001;
  localparam logic [31:0] V_ML  = 32'h4D4D_0002;
  localparam logic [31:0] V_MA  = 32'h3A3A_0003;
  localparam logic [31:0] V_WL  = 32'h5B5B_0004;
  localparam logic [31:0] V_WA  = 32'h6C6C_0005;
  localparam logic [31:0] V_RFA = 32'hAAAA_0000;
  localparam logic [31:0] V_RFB = 32'hBBBB_0000;
  localparam logic [31:0] V_PC  = 32'h0000_1234;

  // Expected-source codes
  localparam logic [2:0] S_RF = 3'd0, S_EX = 3'd1, S_ML = 3'd2, S_MA = 3'd3,
                         S_WL = 3'd4, S_WA = 3'd5, S_PC = 3'd6;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] sa;
    logic [3:0] sb;
    logic [3:0] d_ex;
    logic [3:0] d_ml;
    logic [3:0] d_ma;
    logic [3:0] d_wl;
    logic [3:0] d_wa;
    logic [2:0] exp_a;
    logic [2:0] exp_b;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    //  op     sa     sb     ex     ml     ma     wl     wa     A     B     tag
    '{4'h6, 4'h1, 4'h2, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, S_RF, S_RF, 4'd9},  // R9
    '{4'h6, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, S_RF, S_RF, 4'd7},  // R7
    '{4'h6, 4'h3, 4'h2, 4'h3, 4'hF, 4'hF, 4'hF, 4'hF, S_EX, S_RF, 4'd2},  // R2
    '{4'h6, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, 4'h3, S_EX, S_EX, 4'd2},  // R2
    '{4'h6, 4'h3, 4'h4, 4'hF, 4'h3, 4'h3, 4'h3, 4'h3, S_ML, S_RF, 4'd3},  // R3
    '{4'h6, 4'h5, 4'h5, 4'hF, 4'hF, 4'h5, 4'h5, 4'h5, S_MA, S_MA, 4'd4},  // R4
    '{4'h6, 4'h6, 4'h1, 4'hF, 4'hF, 4'hF, 4'h6, 4'h6, S_WL, S_RF, 4'd5},  // R5
    '{4'h0, 4'h2, 4'h2, 4'hF, 4'h9, 4'h8, 4'h2, 4'h2, S_WL, S_WL, 4'd5},  // R5
    '{4'h6, 4'h7, 4'h7, 4'hF, 4'hF, 4'hF, 4'hF, 4'h7, S_WA, S_WA, 4'd6},  // R6
    '{4'h8, 4'h3, 4'h3, 4'h3, 4'hF, 4'hF, 4'hF, 4'hF, S_PC, S_EX, 4'd1},  // R1
    '{4'h7, 4'hF, 4'h2, 4'hF, 4'hF, 4'hF, 4'hF, 4'h2, S_PC, S_WA, 4'd1},  // R1
    '{4'h8, 4'h1, 4'h5, 4'hF, 4'h5, 4'hF, 4'hF, 4'hF, S_PC, S_ML, 4'd10}, // R10
    '{4'h6, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, S_RF, S_RF, 4'd8},  // R8
    '{4'h6, 4'h9, 4'h9, 4'hF, 4'hF, 4'h9, 4'hF, 4'hF, S_MA, S_MA, 4'd11}, // R11
    '{4'h6, 4'h0, 4'h1, 4'h1, 4'h0, 4'hF, 4'hF, 4'hF, S_ML, S_EX, 4'd11}  // R11
  };

  logic clk;
  logic [OP_W-1:0]   dec_op;
  logic [DATA_W-1:0] dec_next_pc;
  logic [ID_W-1:0]   dec_src_a, dec_src_b;
  logic [DATA_W-1:0] rf_rd_a, rf_rd_b;
  logic [ID_W-1:0]   ex_alu_dst, mem_load_dst, mem_alu_dst, wb_load_dst, wb_alu_dst;
  logic [DATA_W-1:0] ex_alu_res, mem_load_data, mem_alu_val, wb_load_val, wb_alu_val;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  fwd_operand_bypass i_fwd_operand_bypass (
    .dec_op        (dec_op),
    .dec_next_pc   (dec_next_pc),
    .dec_src_a     (dec_src_a),
    .dec_src_b     (dec_src_b),
    .rf_rd_a       (rf_rd_a),
    .rf_rd_b       (rf_rd_b),
    .ex_alu_dst    (ex_alu_dst),
    .ex_alu_res    (ex_alu_res),
    .mem_load_dst  (mem_load_dst),
    .mem_load_data (mem_load_data),
    .mem_alu_dst   (mem_alu_dst),
    .mem_alu_val   (mem_alu_val),
    .wb_load_dst   (wb_load_dst),
    .wb_load_val   (wb_load_val),
    .wb_alu_dst    (wb_alu_dst),
    .wb_alu_val    (wb_alu_val),
    .opnd_a        (opnd_a),
    .opnd_b        (opnd_b)
  );

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] src_value(input logic [2:0] s, input logic [31:0] rf);
    case (s)
      S_EX:    return V_EX;
      S_ML:    return V_ML;
      S_MA:    return V_MA;
      S_WL:    return V_WL;
      S_WA:    return V_WA;
      S_PC:    return V_PC;
      default: return rf;
    endcase
  endfunction

  task automatic compare(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic load_values();
    dec_next_pc   = V_PC;
    rf_rd_a       = V_RFA;
    rf_rd_b       = V_RFB;
    ex_alu_res    = V_EX;
    mem_load_data = V_ML;
    mem_alu_val   = V_MA;
    wb_load_val   = V_WL;
    wb_alu_val    = V_WA;
  endtask

  // Inputs change just after a rising edge; outputs are read at the falling edge.
  initial begin
    dec_op = 4'h6; dec_src_a = 4'hF; dec_src_b = 4'hF;
    ex_alu_dst = 4'hF; mem_load_dst = 4'hF; mem_alu_dst = 4'hF;
    wb_load_dst = 4'hF; wb_alu_dst = 4'hF;
    load_values();

    // Idle state: nothing named, register-file values pass (R8)
    @(negedge clk);
    compare("R8", "idle opnd_a", opnd_a, V_RFA);
    compare("R8", "idle opnd_b", opnd_b, V_RFB);

    for (int v = 0; v < NV; v++) begin
      @(posedge clk); #1;
      dec_op       = VECS[v].op;
      dec_src_a    = VECS[v].sa;
      dec_src_b    = VECS[v].sb;
      ex_alu_dst   = VECS[v].d_ex;
      mem_load_dst = VECS[v].d_ml;
      mem_alu_dst  = VECS[v].d_ma;
      wb_load_dst  = VECS[v].d_wl;
      wb_alu_dst   = VECS[v].d_wa;
      @(negedge clk);
      compare(tag_name(VECS[v].tag), $sformatf("vec %0d opnd_a", v),
              opnd_a, src_value(VECS[v].exp_a, V_RFA));
      compare(tag_name(VECS[v].tag), $sformatf("vec %0d opnd_b", v),
              opnd_b, src_value(VECS[v].exp_b, V_RFB));
    end

    // R2: execute value is taken live; change it with the match held
    @(posedge clk); #1;
    dec_op = 4'h6; dec_src_a = 4'hC; dec_src_b = 4'hC;
    ex_alu_dst = 4'hC; mem_load_dst = 4'hC; mem_alu_dst = 4'hF;
    wb_load_dst = 4'hF; wb_alu_dst = 4'hF;
    @(negedge clk);
    compare("R2", "live ex a", opnd_a, V_EX);
    @(posedge clk); #1;
    ex_alu_res = 32'h1357_9BDF;
    @(negedge clk);
    compare("R2", "updated ex a", opnd_a, 32'h1357_9BDF);
    compare("R2", "updated ex b", opnd_b, 32'h1357_9BDF);

    // R1: PC override tracks next-pc; R10: B keeps the ex value under jump
    @(posedge clk); #1;
    dec_op = 4'h7; dec_next_pc = 32'hCAFE_0040;
    @(negedge clk);
    compare("R1", "jump pc a", opnd_a, 32'hCAFE_0040);
    compare("R10", "jump b", opnd_b, 32'h1357_9BDF);

    // R9: destination none code against a real source
    @(posedge clk); #1;
    load_values();
    dec_op = 4'h2; dec_src_a = 4'hE; dec_src_b = 4'h0;
    ex_alu_dst = 4'hF; mem_load_dst = 4'hF; mem_alu_dst = 4'hF;
    wb_load_dst = 4'hF; wb_alu_dst = 4'hF;
    @(negedge clk);
    compare("R9", "none dst a", opnd_a, V_RFA);
    compare("R9", "none dst b", opnd_b, V_RFB);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule